// File: doc/BRIEF.md
# Accumulator Rounding and Saturation Read-Out

This block turns a wide signed accumulator (four guard bits above a 32-bit fixed-point value) into a 16-bit result word. A command asks for one of two transfers. The truncating transfer takes the upper half of the 32-bit value as it is. The rounding transfer first rounds the accumulator at the result's least significant bit, using round-half-to-even. It then sends the rounded accumulator and its updated overflow flags back through a write-back port. The result is taken from that rounded value.

When saturation mode is enabled, the result is clamped to the largest positive or largest negative 16-bit value. The choice uses the sticky accumulator-overflow flag with its latched sign first, and the guard-bit overflow flag second. Each result carries negative and zero status computed from the 16-bit word. The multiplier-overflow flag passes through as the overflow status.

Commands enter on a valid/ready handshake and results leave on a second valid/ready handshake. A command is accepted only when `cmd_valid` and `cmd_ready` are both high at a clock edge. `cmd_ready` is low while a rounding transfer is in flight, and also while a result is waiting that will not be consumed in the same cycle. A result that is presented stays unchanged until `res_ready` takes it. The accumulator, its flags, the saturation bit and the multiplier flag are sampled only at the edge where the command is accepted.

Top module: `acc_readout`

## Requirements
- R1: After reset, `res_valid` and `wb_valid` are 0 and `cmd_ready` is 1.
- R2: With `sat_mode` = 0, the result equals accumulator bits 31:16, whatever the overflow flags and latched sign are.
- R3: With `sat_mode` = 1 and the sticky overflow flag (`acc_mv`) set, the result is 16'h7FFF when the latched sign `acc_sl` is 1, and 16'h8000 when it is 0.
- R4: With `sat_mode` = 1, `acc_mv` clear and the guard overflow flag (`acc_ev`) set, the result is 16'h8000 when accumulator bit 35 is 1, and 16'h7FFF otherwise.
- R5: With `sat_mode` = 1 and both flags clear, the result equals accumulator bits 31:16.
- R6: A rounding transfer (`cmd_round` = 1) adds 36'h1_0000 to the accumulator (modulo 2^36) when bit 15 is set. The exception is a low half of exactly 16'h8000 with bit 16 equal to 0, in which case nothing is added.
- R7: After the rounding add, the guard flag is 1 exactly when sum bits 35:32 differ from four copies of sum bit 31. The sticky flag is set, with the latched sign taking sum bit 35, when the guard flag is 1, the sticky flag was 0, and bit 35 changed. The sticky flag is never cleared, and the latched sign is kept otherwise. These rounded values appear on `wb_acc`, `wb_ev`, `wb_mv` and `wb_sl`, and saturation is judged on them.
- R8: A truncating transfer (`cmd_round` = 0) raises `res_valid` one cycle after acceptance. A rounding transfer raises `wb_valid` for exactly one cycle, one cycle after acceptance, and raises `res_valid` two cycles after acceptance.
- R9: A truncating transfer never raises `wb_valid`.
- R10: `res_neg` equals result bit 15, `res_zero` is 1 when the result is 0, and `res_ovf` equals `mul_ovf` sampled at acceptance.
- R11: While `res_valid` = 1 and `res_ready` = 0, `res_data` and the status hold and `cmd_ready` is 0. `cmd_ready` is also 0 in the write-back cycle of a rounding transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_round | input | 1 | 0 = truncating transfer, 1 = rounding transfer |
| sat_mode | input | 1 | Saturation enable |
| acc_in | input | 36 | Accumulator value |
| acc_ev | input | 1 | Guard-bit overflow flag |
| acc_mv | input | 1 | Sticky accumulator overflow flag |
| acc_sl | input | 1 | Latched sign of the first overflow |
| mul_ovf | input | 1 | Multiplier overflow flag |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer takes the result |
| res_data | output | 16 | Result word |
| res_neg | output | 1 | Result negative |
| res_zero | output | 1 | Result zero |
| res_ovf | output | 1 | Overflow status (multiplier flag) |
| wb_valid | output | 1 | Write-back of the rounded accumulator |
| wb_acc | output | 36 | Rounded accumulator |
| wb_ev | output | 1 | Updated guard flag |
| wb_mv | output | 1 | Updated sticky flag |
| wb_sl | output | 1 | Updated latched sign |

## Verification
The bench builds the block with its default widths: a 36-bit accumulator and a 16-bit result. With these widths the exact tie case 16'h8000 can be checked with both bit-16 parities. They also allow carries that cross from bit 31 into the guard bits, and wraps that flip bit 35 so the sticky flag is set. Each saturation branch can be checked against the sign it picks. The narrow output register makes back-pressure visible, because a held result blocks the next command.

// File: rtl/acro_pkg.sv
package acro_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WB   = 1'b1
  } acro_state_e;

  typedef struct packed {
    logic ev;
    logic mv;
    logic sl;
  } acro_flags_t;

endpackage

// File: rtl/acro_round.sv
module acro_round
  import acro_pkg::*;
#(
  parameter int ACC_W = 36,
  parameter int RES_W = 16
) (
  input  logic [ACC_W-1:0] acc_i,
  input  acro_flags_t      flags_i,
  output logic [ACC_W-1:0] sum_o,
  output acro_flags_t      flags_o
);
  localparam int FRAC_W  = 2 * RES_W;
  localparam int GUARD_W = ACC_W - FRAC_W;
  localparam logic [RES_W-1:0] TIE = {1'b1, {(RES_W-1){1'b0}}};

  logic             bump;
  logic [ACC_W-1:0] inc;
  logic             guard_bad;
  logic             sign_flip;

  // Round half to even: a tie is left alone when the kept lsb is already even.
  always_comb begin
    bump = acc_i[RES_W-1] && ((acc_i[RES_W-1:0] != TIE) || acc_i[RES_W]);
    inc  = '0;
    inc[RES_W] = bump;
    sum_o = acc_i + inc;
  end

  always_comb begin
    guard_bad = (sum_o[ACC_W-1:FRAC_W] != {GUARD_W{sum_o[FRAC_W-1]}});
    sign_flip = (sum_o[ACC_W-1] != acc_i[ACC_W-1]);
    flags_o.ev = guard_bad;
    if (guard_bad && !flags_i.mv && sign_flip) begin
      flags_o.mv = 1'b1;
      flags_o.sl = sum_o[ACC_W-1];
    end else begin
      flags_o.mv = flags_i.mv;
      flags_o.sl = flags_i.sl;
    end
  end

endmodule

// File: rtl/acro_sat.sv
module acro_sat
  import acro_pkg::*;
#(
  parameter int ACC_W = 36,
  parameter int RES_W = 16
) (
  input  logic             sat_en_i,
  input  logic [ACC_W-1:0] acc_i,
  input  acro_flags_t      flags_i,
  output logic [RES_W-1:0] res_o
);
  localparam logic [RES_W-1:0] POS_MAX = {1'b0, {(RES_W-1){1'b1}}};
  localparam logic [RES_W-1:0] NEG_MAX = {1'b1, {(RES_W-1){1'b0}}};

  logic [RES_W-1:0] field;

  assign field = acc_i[2*RES_W-1:RES_W];

  // Sticky overflow outranks guard overflow.
  always_comb begin
    if (!sat_en_i)         res_o = field;
    else if (flags_i.mv)   res_o = flags_i.sl ? POS_MAX : NEG_MAX;
    else if (flags_i.ev)   res_o = acc_i[ACC_W-1] ? NEG_MAX : POS_MAX;
    else                   res_o = field;
  end

endmodule

// File: rtl/acro_ctrl.sv
module acro_ctrl
  import acro_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_valid_i,
  input  logic cmd_round_i,
  input  logic res_ready_i,
  output logic cmd_ready_o,
  output logic ld_round_o,
  output logic res_load_o,
  output logic wb_phase_o,
  output logic res_valid_o
);
  acro_state_e state_q;
  logic        fire;
  logic        ld_trunc;

  assign cmd_ready_o = (state_q == ST_IDLE) && (!res_valid_o || res_ready_i);
  assign fire        = cmd_valid_i && cmd_ready_o;
  assign ld_trunc    = fire && !cmd_round_i;
  assign ld_round_o  = fire && cmd_round_i;
  assign wb_phase_o  = (state_q == ST_WB);
  assign res_load_o  = ld_trunc || wb_phase_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      res_valid_o <= 1'b0;
    end else begin
      state_q <= ld_round_o ? ST_WB : ST_IDLE;
      if (res_load_o)       res_valid_o <= 1'b1;
      else if (res_ready_i) res_valid_o <= 1'b0;
    end
  end

  assert_round_wb_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && cmd_ready_o && cmd_round_i) |=> (wb_phase_o && !res_valid_o));

  assert_wb_then_res_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wb_phase_o |=> (res_valid_o && !wb_phase_o));

  assert_trunc_no_wb_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && cmd_ready_o && !cmd_round_i) |=> (res_valid_o && !wb_phase_o));

  assert_busy_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wb_phase_o |-> !cmd_ready_o);

endmodule

// File: rtl/acc_readout.sv
module acc_readout
  import acro_pkg::*;
#(
  parameter int ACC_W = 36,
  parameter int RES_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic             cmd_round,
  input  logic             sat_mode,
  input  logic [ACC_W-1:0] acc_in,
  input  logic             acc_ev,
  input  logic             acc_mv,
  input  logic             acc_sl,
  input  logic             mul_ovf,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [RES_W-1:0] res_data,
  output logic             res_neg,
  output logic             res_zero,
  output logic             res_ovf,
  output logic             wb_valid,
  output logic [ACC_W-1:0] wb_acc,
  output logic             wb_ev,
  output logic             wb_mv,
  output logic             wb_sl
);
  acro_flags_t      flags_in;
  acro_flags_t      flags_rnd;
  acro_flags_t      flags_q;
  acro_flags_t      sat_flags;
  logic [ACC_W-1:0] sum_rnd;
  logic [ACC_W-1:0] sum_q;
  logic [ACC_W-1:0] sat_acc;
  logic [RES_W-1:0] sat_res;
  logic             sat_en;
  logic             sat_q;
  logic             mof_q;
  logic             ld_round;
  logic             res_load;
  logic             wb_phase;

  assign flags_in = '{ev: acc_ev, mv: acc_mv, sl: acc_sl};

  acro_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid_i (cmd_valid),
    .cmd_round_i (cmd_round),
    .res_ready_i (res_ready),
    .cmd_ready_o (cmd_ready),
    .ld_round_o  (ld_round),
    .res_load_o  (res_load),
    .wb_phase_o  (wb_phase),
    .res_valid_o (res_valid)
  );

  acro_round #(.ACC_W(ACC_W), .RES_W(RES_W)) u_round (
    .acc_i   (acc_in),
    .flags_i (flags_in),
    .sum_o   (sum_rnd),
    .flags_o (flags_rnd)
  );

  // Rounded accumulator and flags held for the write-back cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q   <= '0;
      flags_q <= '0;
      sat_q   <= 1'b0;
      mof_q   <= 1'b0;
    end else if (ld_round) begin
      sum_q   <= sum_rnd;
      flags_q <= flags_rnd;
      sat_q   <= sat_mode;
      mof_q   <= mul_ovf;
    end
  end

  assign sat_acc   = wb_phase ? sum_q   : acc_in;
  assign sat_flags = wb_phase ? flags_q : flags_in;
  assign sat_en    = wb_phase ? sat_q   : sat_mode;

  acro_sat #(.ACC_W(ACC_W), .RES_W(RES_W)) u_sat (
    .sat_en_i (sat_en),
    .acc_i    (sat_acc),
    .flags_i  (sat_flags),
    .res_o    (sat_res)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_data <= '0;
      res_neg  <= 1'b0;
      res_zero <= 1'b0;
      res_ovf  <= 1'b0;
    end else if (res_load) begin
      res_data <= sat_res;
      res_neg  <= sat_res[RES_W-1];
      res_zero <= (sat_res == '0);
      res_ovf  <= wb_phase ? mof_q : mul_ovf;
    end
  end

  assign wb_valid = wb_phase;
  assign wb_acc   = sum_q;
  assign wb_ev    = flags_q.ev;
  assign wb_mv    = flags_q.mv;
  assign wb_sl    = flags_q.sl;

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data) && $stable(res_neg)));

  assert_sticky_wb_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_round && acc_mv) |=> wb_mv);

endmodule

// File: tb/acc_readout_tb_top.sv
`timescale 1ns/1ps
module acc_readout_tb_top;

  typedef struct packed {
    logic        rnd;
    logic        sat;
    logic        mv;
    logic        ev;
    logic        sl;
    logic        mof;
    logic [35:0] acc;
    logic [15:0] res;
    logic [35:0] wacc;
    logic        wev;
    logic        wmv;
    logic        wsl;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t TBL [NV] = '{
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 36'h0_1234_5678, 16'h1234, 36'h0, 1'b0,1'b0,1'b0},
    '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b0, 36'hF_8000_0000, 16'h8000, 36'h0, 1'b0,1'b0,1'b0},
    '{1'b0,1'b1,1'b1,1'b0,1'b1,1'b1, 36'h0_0000_0000, 16'h7FFF, 36'h0, 1'b0,1'b0,1'b0},
    '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0, 36'h0_0000_0000, 16'h8000, 36'h0, 1'b0,1'b0,1'b0},
    '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b0, 36'h8_0000_0000, 16'h8000, 36'h0, 1'b0,1'b0,1'b0},
    '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b0, 36'h1_0000_0000, 16'h7FFF, 36'h0, 1'b0,1'b0,1'b0},
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 36'h0_0000_0000, 16'h0000, 36'h0, 1'b0,1'b0,1'b0},
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b1, 36'h0_0001_8000, 16'h0002, 36'h0_0002_8000, 1'b0,1'b0,1'b0},
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 36'h0_0002_8000, 16'h0002, 36'h0_0002_8000, 1'b0,1'b0,1'b0},
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 36'h0_0002_8001, 16'h0003, 36'h0_0003_8001, 1'b0,1'b0,1'b0},
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 36'h0_0002_7FFF, 16'h0002, 36'h0_0002_7FFF, 1'b0,1'b0,1'b0},
    '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 36'h0_7FFF_8000, 16'h7FFF, 36'h0_8000_8000, 1'b1,1'b0,1'b0},
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0, 36'h7_FFFF_8000, 16'h7FFF, 36'h8_0000_8000, 1'b1,1'b1,1'b1},
    '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0, 36'hF_FFFF_8000, 16'h0000, 36'h0_0000_8000, 1'b0,1'b0,1'b0},
    '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b0, 36'h0_0001_0000, 16'h8000, 36'h0_0001_0000, 1'b0,1'b1,1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic        cmd_round = 1'b0;
  logic        sat_mode = 1'b0;
  logic [35:0] acc_in = '0;
  logic        acc_ev = 1'b0;
  logic        acc_mv = 1'b0;
  logic        acc_sl = 1'b0;
  logic        mul_ovf = 1'b0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic [15:0] res_data;
  logic        res_neg, res_zero, res_ovf;
  logic        wb_valid;
  logic [35:0] wb_acc;
  logic        wb_ev, wb_mv, wb_sl;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  acc_readout dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_round(cmd_round), .sat_mode(sat_mode), .acc_in(acc_in),
    .acc_ev(acc_ev), .acc_mv(acc_mv), .acc_sl(acc_sl), .mul_ovf(mul_ovf),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
    .res_neg(res_neg), .res_zero(res_zero), .res_ovf(res_ovf),
    .wb_valid(wb_valid), .wb_acc(wb_acc), .wb_ev(wb_ev), .wb_mv(wb_mv), .wb_sl(wb_sl)
  );

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    cmd_round = v.rnd; sat_mode = v.sat; acc_in = v.acc;
    acc_ev = v.ev; acc_mv = v.mv; acc_sl = v.sl; mul_ovf = v.mof;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 res_valid", res_valid, 0);
    chk("R1 wb_valid", wb_valid, 0);
    chk("R1 cmd_ready", cmd_ready, 1);

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i]);
      cmd_valid = 1'b1;
      chk("R11 ready before issue", cmd_ready, 1);
      @(negedge clk);
      cmd_valid = 1'b0;
      if (TBL[i].rnd) begin
        chk("R8 wb pulse", wb_valid, 1);
        chk("R8 result not yet", res_valid, 0);
        chk("R11 busy in wb cycle", cmd_ready, 0);
        chk("R6 R7 wb_acc", wb_acc, TBL[i].wacc);
        chk("R7 wb_ev", wb_ev, TBL[i].wev);
        chk("R7 wb_mv", wb_mv, TBL[i].wmv);
        chk("R7 wb_sl", wb_sl, TBL[i].wsl);
        @(negedge clk);
        chk("R8 wb one cycle", wb_valid, 0);
      end else begin
        chk("R9 no write-back", wb_valid, 0);
      end
      chk("R8 res_valid", res_valid, 1);
      chk(TBL[i].rnd ? "R6 R7 result" : "R2 R3 R4 R5 result", res_data, TBL[i].res);
      chk("R10 neg", res_neg, TBL[i].res[15]);
      chk("R10 zero", res_zero, TBL[i].res == 16'h0);
      chk("R10 ovf", res_ovf, TBL[i].mof);
      @(negedge clk);
      chk("R8 result consumed", res_valid, 0);
    end

    // Back-pressure: held result blocks commands and stays stable.
    res_ready = 1'b0;
    drive(TBL[0]);
    cmd_valid = 1'b1;
    @(negedge clk);
    chk("R11 result presented", res_valid, 1);
    for (int k = 0; k < 3; k++) begin
      drive(TBL[2]);
      cmd_valid = 1'b1;
      @(negedge clk);
      chk("R11 ready low while held", cmd_ready, 0);
      chk("R11 data held", res_data, 16'h1234);
      chk("R11 valid held", res_valid, 1);
    end
    cmd_valid = 1'b0;
    res_ready = 1'b1;
    @(negedge clk);
    chk("R11 released", res_valid, 0);
    chk("R11 ready again", cmd_ready, 1);

    // Truncating transfer leaves the accumulator untouched (no write-back).
    drive(TBL[7]);
    cmd_round = 1'b0;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R9 trunc no wb", wb_valid, 0);
    chk("R2 trunc of tie value", res_data, 16'h0001);
    @(negedge clk);
    chk("R9 still no wb", wb_valid, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule